// File: doc/BRIEF.md
# Fast Ethernet Controller Register Bank

This block is the software-visible control surface of a fast Ethernet controller. A host writes and reads it over a simple single-cycle bus: a select, a write enable, a word offset within the controller's register window, write data and combinational read data. The bank holds the base addresses of the receive and transmit descriptor rings, the receive buffer size, the controller's enable/reset control word, and a set of interrupt event, mask and vector registers. It also holds the current ring pointers handed to the descriptor engine and the data word handed to the management-interface serial engine.

The descriptor engine, the MAC datapath and the management serial engine sit outside the block. Their status comes back as one-cycle event strobes that set event bits. The block returns a level interrupt to the interrupt controller. It also gives two one-cycle pulses: one tells the transmit side that new descriptors are ready, and the other starts a management transaction.

The bus offset is a word index: index = (byte offset - 0xE00) / 4. So 0xE10 is index 4 and 0xE80 is index 32.

Top module: `eth_ctl_regs`

## Requirements
- R1: Word index 4 (byte 0xE10) holds the receive ring start and index 5 (byte 0xE14) holds the transmit ring start. Both read back the written value with bits 1:0 forced to zero.
- R2: Word index 6 (byte 0xE18) holds the receive buffer size. Only bits 10:4 are stored, and every other bit reads as zero.
- R3: A write to the control word at index 16 (byte 0xE40) with bit 0 (soft reset) set leaves the control word at zero, whatever the other data bits are.
- R4: A control write with bit 0 clear stores the data. If bit 1 (enable) is also clear, the same write loads `rx_cur` and `tx_cur` from the two ring start registers one cycle later. If bit 1 is set, the current pointers are unchanged.
- R5: The event register at index 17 (byte 0xE44) reads pending events. A write to it clears each bit that is 1 in the write data and leaves the other bits unchanged.
- R6: A 1 on `evt_set[i]` sets event bit i, and `mgmt_done` sets event bit 23. Each of these wins over a clear of the same bit in the same cycle.
- R7: The mask at index 18 (byte 0xE48) and the vector at index 19 (byte 0xE4C) are plain 32-bit read/write registers.
- R8: `irq` is high exactly when (event AND mask) is non-zero, lagging the event and mask registers by one cycle.
- R9: Any access, read or write, to index 21 (byte 0xE54) produces a single-cycle `tx_kick` pulse on the following cycle. That index reads as zero.
- R10: A write to index 32 (byte 0xE80) stores the value, drives it on `mgmt_data`, and pulses `mgmt_start` for one cycle on the following cycle. A read of that index gives no pulse.
- R11: Indices with no register read as zero, and writes to them change no register or output. `bus_rdata` is zero when no read is in progress.
- R12: After reset every register, both current pointers, `irq`, `tx_kick` and `mgmt_start` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word index within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access |
| evt_set | input | 32 | Per-bit event set strobes from the datapath engines |
| mgmt_done | input | 1 | Management transaction completion strobe |
| irq | output | 1 | Level interrupt request |
| tx_kick | output | 1 | One-cycle pulse: transmit descriptors ready |
| mgmt_start | output | 1 | One-cycle pulse: start a management transaction |
| mgmt_data | output | 32 | Management data word for the serial engine |
| rx_cur | output | 32 | Current receive descriptor pointer |
| tx_cur | output | 32 | Current transmit descriptor pointer |
| eth_en | output | 1 | Control word bit 1, the controller enable |

## Verification
The assertions take for granted that the bus makes at most one access per cycle, and that `bus_addr`, `bus_we` and `bus_wdata` are stable while `bus_sel` is high. They also assume that the strobe inputs are single-cycle pulses that come from synchronous logic and are low during reset. The bench drives all bus and strobe inputs on the falling clock edge, keeps every access to exactly one cycle, and returns the strobes to zero after one cycle. The only overlap it creates on purpose is a set strobe and an event-register clear in the same cycle, to exercise the set-wins rule.

// File: rtl/eth_ctl_pkg.sv
package eth_ctl_pkg;

  // Word indices inside the register window; software depends on these.
  localparam int unsigned W_RX_START  = 4;
  localparam int unsigned W_TX_START  = 5;
  localparam int unsigned W_BUF_SIZE  = 6;
  localparam int unsigned W_CTRL      = 16;
  localparam int unsigned W_EVENT     = 17;
  localparam int unsigned W_MASK      = 18;
  localparam int unsigned W_VECTOR    = 19;
  localparam int unsigned W_TX_KICK   = 21;
  localparam int unsigned W_MGMT_DATA = 32;

  typedef struct packed {
    logic rx_start;
    logic tx_start;
    logic buf_size;
    logic ctrl;
    logic evt;
    logic mask;
    logic vector;
    logic mgmt;
  } wr_strb_t;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_RXS,
    RD_TXS,
    RD_BSZ,
    RD_CTL,
    RD_EVT,
    RD_MSK,
    RD_VEC,
    RD_MGT
  } rd_sel_t;

endpackage

// File: rtl/eth_ctl_decode.sv
module eth_ctl_decode
  import eth_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output wr_strb_t          wr,
  output rd_sel_t           rd,
  output logic              kick_hit,
  output logic              mgmt_hit
);

  wr_strb_t hit;

  always_comb begin
    hit = '0;
    rd  = RD_NONE;
    case (addr)
      ADDR_W'(W_RX_START):  begin hit.rx_start = 1'b1; rd = RD_RXS; end
      ADDR_W'(W_TX_START):  begin hit.tx_start = 1'b1; rd = RD_TXS; end
      ADDR_W'(W_BUF_SIZE):  begin hit.buf_size = 1'b1; rd = RD_BSZ; end
      ADDR_W'(W_CTRL):      begin hit.ctrl     = 1'b1; rd = RD_CTL; end
      ADDR_W'(W_EVENT):     begin hit.evt      = 1'b1; rd = RD_EVT; end
      ADDR_W'(W_MASK):      begin hit.mask     = 1'b1; rd = RD_MSK; end
      ADDR_W'(W_VECTOR):    begin hit.vector   = 1'b1; rd = RD_VEC; end
      ADDR_W'(W_MGMT_DATA): begin hit.mgmt     = 1'b1; rd = RD_MGT; end
      default:              begin hit = '0;            rd = RD_NONE; end
    endcase
    if (!(sel && !we)) begin
      rd = RD_NONE;
    end
  end

  assign wr       = (sel && we) ? hit : '0;
  assign kick_hit = sel && (addr == ADDR_W'(W_TX_KICK));
  assign mgmt_hit = sel && we && (addr == ADDR_W'(W_MGMT_DATA));

endmodule

// File: rtl/eth_ctl_ring.sv
module eth_ctl_ring #(
  parameter int unsigned DW         = 32,
  parameter int unsigned RING_ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          wr_rx_start,
  input  logic          wr_tx_start,
  input  logic          rewind,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rx_start,
  output logic [DW-1:0] tx_start,
  output logic [DW-1:0] rx_cur,
  output logic [DW-1:0] tx_cur
);

  localparam logic [DW-1:0] ALIGN_MASK = {DW{1'b1}} << RING_ALIGN;

  logic [DW-1:0] rx_start_d, tx_start_d, rx_cur_d, tx_cur_d;

  always_comb begin
    rx_start_d = rx_start;
    tx_start_d = tx_start;
    rx_cur_d   = rx_cur;
    tx_cur_d   = tx_cur;
    if (wr_rx_start) rx_start_d = wdata & ALIGN_MASK;
    if (wr_tx_start) tx_start_d = wdata & ALIGN_MASK;
    if (rewind) begin
      rx_cur_d = rx_start;
      tx_cur_d = tx_start;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rx_start <= '0;
      tx_start <= '0;
      rx_cur   <= '0;
      tx_cur   <= '0;
    end else begin
      rx_start <= rx_start_d;
      tx_start <= tx_start_d;
      rx_cur   <= rx_cur_d;
      tx_cur   <= tx_cur_d;
    end
  end

  // R1: a start write lands with its low alignment bits cleared
  p_align_r1: assert property (@(posedge clk) disable iff (!rst_q)
    wr_rx_start |=> (rx_start == ($past(wdata) & ALIGN_MASK)));

  // R4: rewind copies the start values seen in the write cycle
  p_rewind_r4: assert property (@(posedge clk) disable iff (!rst_q)
    rewind |=> (rx_cur == $past(rx_start)) && (tx_cur == $past(tx_start)));

  // R4: without rewind the current pointers hold
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_q)
    !rewind |=> $stable(rx_cur) && $stable(tx_cur));

endmodule

// File: rtl/eth_ctl_irq.sv
module eth_ctl_irq #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          wr_evt,
  input  logic          wr_msk,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] set_vec,
  output logic [DW-1:0] evt_q,
  output logic [DW-1:0] msk_q,
  output logic          irq
);

  logic [DW-1:0] clr_vec, evt_d, msk_d;
  logic          irq_d;

  always_comb begin
    clr_vec = wr_evt ? wdata : '0;
    evt_d   = (evt_q & ~clr_vec) | set_vec;
    msk_d   = wr_msk ? wdata : msk_q;
    irq_d   = |(evt_q & msk_q);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      evt_q <= '0;
      msk_q <= '0;
      irq   <= 1'b0;
    end else begin
      evt_q <= evt_d;
      msk_q <= msk_d;
      irq   <= irq_d;
    end
  end

  // R6: a strobed bit is pending on the next cycle even under a clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (|set_vec) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

  // R5: bits written as one and not re-set are gone on the next cycle
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_q)
    wr_evt |=> ((evt_q & $past(wdata & ~set_vec)) == '0));

  // R5: without a write, event bits can only gain
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_evt |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R8: the interrupt can only drop two cycles after a clear or mask write
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(irq) |-> $past(wr_evt || wr_msk, 2));

  // R8: the interrupt can only rise two cycles after a set or mask write
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(irq) |-> $past((|set_vec) || wr_msk, 2));

endmodule

// File: rtl/eth_ctl_regs.sv
module eth_ctl_regs
  import eth_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DW          = 32,
  parameter int unsigned RING_ALIGN  = 2,
  parameter int unsigned BSZ_LO      = 4,
  parameter int unsigned BSZ_HI      = 10,
  parameter int unsigned CTL_RST_BIT = 0,
  parameter int unsigned CTL_EN_BIT  = 1,
  parameter int unsigned MII_EVT_BIT = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     evt_set,
  input  logic              mgmt_done,
  output logic              irq,
  output logic              tx_kick,
  output logic              mgmt_start,
  output logic [DW-1:0]     mgmt_data,
  output logic [DW-1:0]     rx_cur,
  output logic [DW-1:0]     tx_cur,
  output logic              eth_en
);

  localparam logic [DW-1:0] BSZ_MASK =
    ({DW{1'b1}} << BSZ_LO) & ~({DW{1'b1}} << (BSZ_HI + 1));
  localparam logic [DW-1:0] MII_SET = DW'(1) << MII_EVT_BIT;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // Decode
  wr_strb_t wr;
  rd_sel_t  rd;
  logic     kick_hit, mgmt_hit;

  eth_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .sel      (bus_sel),
    .we       (bus_we),
    .addr     (bus_addr),
    .wr       (wr),
    .rd       (rd),
    .kick_hit (kick_hit),
    .mgmt_hit (mgmt_hit)
  );

  // Control word and plain registers
  logic [DW-1:0] ctl_q, ctl_d;
  logic [DW-1:0] bsz_q, bsz_d;
  logic [DW-1:0] vec_q, vec_d;
  logic [DW-1:0] mgt_q, mgt_d;
  logic          kick_d, mgo_d;
  logic          rewind;

  always_comb begin
    ctl_d  = ctl_q;
    rewind = 1'b0;
    if (wr.ctrl) begin
      if (bus_wdata[CTL_RST_BIT]) begin
        ctl_d = '0;
      end else begin
        rewind = !bus_wdata[CTL_EN_BIT];
        ctl_d  = bus_wdata;
      end
    end
    bsz_d  = wr.buf_size ? (bus_wdata & BSZ_MASK) : bsz_q;
    vec_d  = wr.vector   ? bus_wdata : vec_q;
    mgt_d  = wr.mgmt     ? bus_wdata : mgt_q;
    kick_d = kick_hit;
    mgo_d  = mgmt_hit;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctl_q      <= '0;
      bsz_q      <= '0;
      vec_q      <= '0;
      mgt_q      <= '0;
      tx_kick    <= 1'b0;
      mgmt_start <= 1'b0;
    end else begin
      ctl_q      <= ctl_d;
      bsz_q      <= bsz_d;
      vec_q      <= vec_d;
      mgt_q      <= mgt_d;
      tx_kick    <= kick_d;
      mgmt_start <= mgo_d;
    end
  end

  // Ring pointers
  logic [DW-1:0] rx_start, tx_start;

  eth_ctl_ring #(.DW(DW), .RING_ALIGN(RING_ALIGN)) u_ring (
    .clk         (clk),
    .rst_q       (rst_q),
    .wr_rx_start (wr.rx_start),
    .wr_tx_start (wr.tx_start),
    .rewind      (rewind),
    .wdata       (bus_wdata),
    .rx_start    (rx_start),
    .tx_start    (tx_start),
    .rx_cur      (rx_cur),
    .tx_cur      (tx_cur)
  );

  // Events and interrupt
  logic [DW-1:0] evt_q, msk_q, set_vec;

  assign set_vec = evt_set | (mgmt_done ? MII_SET : '0);

  eth_ctl_irq #(.DW(DW)) u_irq (
    .clk     (clk),
    .rst_q   (rst_q),
    .wr_evt  (wr.evt),
    .wr_msk  (wr.mask),
    .wdata   (bus_wdata),
    .set_vec (set_vec),
    .evt_q   (evt_q),
    .msk_q   (msk_q),
    .irq     (irq)
  );

  // Read mux
  always_comb begin
    case (rd)
      RD_RXS:  bus_rdata = rx_start;
      RD_TXS:  bus_rdata = tx_start;
      RD_BSZ:  bus_rdata = bsz_q;
      RD_CTL:  bus_rdata = ctl_q;
      RD_EVT:  bus_rdata = evt_q;
      RD_MSK:  bus_rdata = msk_q;
      RD_VEC:  bus_rdata = vec_q;
      RD_MGT:  bus_rdata = mgt_q;
      default: bus_rdata = '0;
    endcase
  end

  assign mgmt_data = mgt_q;
  assign eth_en    = ctl_q[CTL_EN_BIT];

  // R11: at most one register is written per cycle
  p_one_write_r11: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(wr));

  // R11: nothing reads back outside a read access
  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_sel && !bus_we) |-> (bus_rdata == '0));

  // R3: a soft-reset control write leaves zero
  p_ctl_clear_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (wr.ctrl && bus_wdata[CTL_RST_BIT]) |=> (ctl_q == '0));

  // R2: buffer size keeps only its field
  p_bsz_field_r2: assert property (@(posedge clk) disable iff (!rst_q)
    wr.buf_size |=> (bsz_q == ($past(bus_wdata) & BSZ_MASK)));

  // R9: every kick pulse traces back to an access of the kick index
  p_kick_src_r9: assert property (@(posedge clk) disable iff (!rst_q)
    tx_kick |-> $past(bus_sel && (bus_addr == ADDR_W'(W_TX_KICK))));

  // R9: every access of the kick index yields a pulse
  p_kick_go_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel && (bus_addr == ADDR_W'(W_TX_KICK))) |=> tx_kick);

  // R10: a start pulse follows a management write and carries its data
  p_mgmt_src_r10: assert property (@(posedge clk) disable iff (!rst_q)
    mgmt_start |-> $past(bus_sel && bus_we && (bus_addr == ADDR_W'(W_MGMT_DATA)))
                   && (mgmt_data == $past(bus_wdata)));

endmodule

// File: tb/eth_ctl_regs_tb.sv
module eth_ctl_regs_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, evt_set;
  logic        mgmt_done, irq, tx_kick, mgmt_start, eth_en;
  logic [31:0] mgmt_data, rx_cur, tx_cur;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eth_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .mgmt_done(mgmt_done), .irq(irq), .tx_kick(tx_kick),
    .mgmt_start(mgmt_start), .mgmt_data(mgmt_data), .rx_cur(rx_cur),
    .tx_cur(tx_cur), .eth_en(eth_en)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model
  logic [31:0] m_rxs, m_txs, m_bsz, m_ctl, m_evt, m_msk, m_vec, m_mgt, m_rxc, m_txc;
  logic        got_kick, got_mgmt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input int a);
    case (a)
      4: return m_rxs;  5: return m_txs;  6: return m_bsz;
      16: return m_ctl; 17: return m_evt; 18: return m_msk;
      19: return m_vec; 32: return m_mgt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int a);
    case (a)
      4, 5: return "R1";  6: return "R2";  16: return "R3";
      17: return "R5";    18, 19: return "R7";
      21: return "R9";    32: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic do_write(input int a, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a[5:0]; bus_wdata = d; evt_set = s;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; evt_set = '0;
    got_kick = tx_kick; got_mgmt = mgmt_start;
    case (a)
      4: m_rxs = d & 32'hFFFF_FFFC;
      5: m_txs = d & 32'hFFFF_FFFC;
      6: m_bsz = d & 32'h0000_07F0;
      16: begin
        if (d[0]) m_ctl = '0;
        else begin
          if (!d[1]) begin m_rxc = m_rxs; m_txc = m_txs; end
          m_ctl = d;
        end
      end
      17: m_evt = m_evt & ~d;
      18: m_msk = d;
      19: m_vec = d;
      32: m_mgt = d;
      default: ;
    endcase
    m_evt = m_evt | s;
  endtask

  task automatic do_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a[5:0];
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
    got_kick = tx_kick; got_mgmt = mgmt_start;
  endtask

  task automatic pulse_set(input logic [31:0] s, input logic md);
    @(negedge clk);
    evt_set = s; mgmt_done = md;
    @(negedge clk);
    evt_set = '0; mgmt_done = 1'b0;
    m_evt = m_evt | s | (md ? 32'h0080_0000 : 32'h0);
  endtask

  task automatic sweep(input logic [31:0] base);
    logic [31:0] rv;
    for (int a = 0; a < 64; a++) begin
      do_write(a, base ^ {4{8'(a)}}, 32'h0);
      chk("R9 kick after write", {31'b0, got_kick}, {31'b0, a == 21});
      chk("R10 start after write", {31'b0, got_mgmt}, {31'b0, a == 32});
      chk("R4 rx_cur", rx_cur, m_rxc);
      chk("R4 tx_cur", tx_cur, m_txc);
      chk("R10 mgmt_data", mgmt_data, m_mgt);
      chk("R4 eth_en", {31'b0, eth_en}, {31'b0, m_ctl[1]});
    end
    for (int a = 0; a < 64; a++) begin
      do_read(a, rv);
      chk(req_of(a), rv, m_read(a));
      chk("R9 kick after read", {31'b0, got_kick}, {31'b0, a == 21});
      chk("R10 no start on read", {31'b0, got_mgmt}, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; evt_set = '0; mgmt_done = 1'b0;
    {m_rxs, m_txs, m_bsz, m_ctl, m_evt, m_msk, m_vec, m_mgt, m_rxc, m_txc} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    chk("R12 irq", {31'b0, irq}, 32'h0);
    chk("R12 tx_kick", {31'b0, tx_kick}, 32'h0);
    chk("R12 mgmt_start", {31'b0, mgmt_start}, 32'h0);
    chk("R12 rx_cur", rx_cur, 32'h0);
    chk("R12 tx_cur", tx_cur, 32'h0);
    chk("R12 idle rdata R11", bus_rdata, 32'h0);
    for (int a = 0; a < 64; a++) begin
      do_read(a, rv);
      chk("R12 register", rv, 32'h0);
    end

    // Full-window sweeps; the patterns hit soft reset, enable and rewind cases
    sweep(32'hFFFF_FFFF);
    sweep(32'h5A5A_F0F2);
    sweep(32'h1234_5678);

    // R3: soft reset beats every other data bit
    do_write(16, 32'hFFFF_FFFF, 32'h0);
    do_read(16, rv);
    chk("R3 soft reset", rv, 32'h0);

    // R4: enabled control write keeps pointers, disabled one rewinds
    do_write(4, 32'h0000_1003, 32'h0);
    do_write(5, 32'h0000_2007, 32'h0);
    do_write(16, 32'h0000_0002, 32'h0);
    chk("R4 enabled keeps rx", rx_cur, m_rxc);
    do_write(16, 32'h0000_0000, 32'h0);
    chk("R4 rewind rx", rx_cur, 32'h0000_1000);
    chk("R4 rewind tx", tx_cur, 32'h0000_2004);

    // R5/R6: clear and set collide
    do_write(18, 32'h0, 32'h0);
    do_write(17, 32'hFFFF_FFFF, 32'h0);
    pulse_set(32'h0000_00F0, 1'b0);
    do_write(17, 32'h0000_0030, 32'h0000_0010);
    do_read(17, rv);
    chk("R6 set wins over clear", rv, 32'h0000_00D0);
    pulse_set(32'h0, 1'b1);
    do_read(17, rv);
    chk("R6 management done bit 23", rv, 32'h0080_00D0);

    // R8: per-bit interrupt with one-cycle lag
    for (int i = 0; i < 32; i++) begin
      do_write(17, 32'hFFFF_FFFF, 32'h0);
      do_write(18, 32'h1 << i, 32'h0);
      @(negedge clk);
      chk("R8 quiet with no event", {31'b0, irq}, 32'h0);
      pulse_set(32'h1 << ((i + 1) % 32), 1'b0);
      @(negedge clk);
      chk("R8 unmasked event ignored", {31'b0, irq}, 32'h0);
      pulse_set(32'h1 << i, 1'b0);
      chk("R8 lag cycle", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R8 asserted", {31'b0, irq}, 32'h1);
      do_write(18, 32'h0, 32'h0);
      @(negedge clk);
      chk("R8 masked off", {31'b0, irq}, 32'h0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule